// File: doc/BRIEF.md
# Reload Timer with Selectable Prescaler

This block is an 8-bit up-counting timer on a small synchronous register port. A free-running 10-bit divider runs off the system clock. One of four divider taps, chosen by a two-bit rate code, produces the counting tick. While the run bit is set, each tick advances the counter by one. When the counter steps past its maximum value, it does not return to zero. It loads a programmable reload value, so software sets the overflow period by choosing the start point of each pass.

Every overflow produces a one-clock request pulse. A flag register latches that pulse and holds it until software writes the flag register. Register selection uses a two-bit address: 0 is the counter, 1 is the reload value, 2 is the control register and 3 is the flag register. Reads are combinational from the address. Writes take effect on the clock edge where the write strobe is high.

With a 4.194304 MHz clock, the four rate codes give 4.096, 262.144, 65.536 and 16.384 kHz. The code order is not monotonic: code 0 is the slowest rate and code 1 is the fastest.

Top module: `reload_timer`

## Requirements
- R1: After reset, the counter, reload, control and flag registers all read 0, and `irq_o` is low.
- R2: The counter (address 0) and reload (address 1) registers read back the full 8-bit value written. The control register (address 2) keeps bits 2:0 and reads 0 in bits 7:3.
- R3: While running, the counter advances once every 1024, 16, 64 or 256 clocks for rate code (control bits 1:0) 0, 1, 2 or 3 respectively.
- R4: While control bit 2 (run) is 0, the counter holds its value and no overflow occurs.
- R5: A tick that finds the counter at 0xFF loads the counter with the reload register's value instead of 0.
- R6: Each overflow drives `irq_o` high for exactly one clock, in the first cycle in which the counter shows the reloaded value.
- R7: Bit 2 of the flag register (address 3) is set by an overflow pulse and is otherwise changed only by a bus write, which loads it from data bit 2. All other flag bits read 0.
- R8: A bus write to the counter in the same cycle as a tick wins. The counter takes the written value, with no increment and no overflow.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Synchronous active-low reset |
| bus_addr | input | 2 | Register select |
| bus_wr | input | 1 | Write strobe |
| bus_wdata | input | 8 | Write data |
| bus_rdata | output | 8 | Read data for the selected register |
| irq_o | output | 1 | One-clock overflow request pulse |
| irq_flag_o | output | 1 | Latched timer request (flag bit 2) |

## Verification
The assertions check these properties on every cycle:
- an overflowing tick loads the reload value, and a counter write lands unchanged;
- the counter stays frozen while the run bit is clear;
- `irq_o` lasts one cycle and is always followed by a set flag.

Only the bench scenarios can show the tick spacing for each rate code, the exact cycle alignment of a write against a tick, and the register read-back masking. These depend on observing many cycles across the port.

// File: rtl/reload_timer_pkg.sv
// Package: shared register selects, bit positions and divider tap mapping
// for the reload timer. Assumes a divider at least 8 bits wide.
package reload_timer_pkg;

    localparam int ADDR_W    = 2;
    localparam int CTRL_W    = 3;
    localparam int RUN_BIT   = 2;
    localparam int TIMER_BIT = 2;
    localparam int NUM_RATES = 4;

    typedef enum logic [ADDR_W-1:0] {
        SEL_COUNT  = 2'd0,
        SEL_RELOAD = 2'd1,
        SEL_CTRL   = 2'd2,
        SEL_FLAG   = 2'd3
    } reg_sel_e;

    // Divider bit whose falling edge clocks the counter for a rate code:
    // code 0 uses the top bit, codes 1..3 use bits 3, 5, 7.
    function automatic int tap_index(input int code, input int div_w);
        return (code == 0) ? div_w - 1 : 2 * code + 1;
    endfunction

endpackage

// File: rtl/rt_prescaler.sv
// Module: free-running divider with four tap edge detectors.
// Emits a one-cycle tick in the cycle before the selected tap falls,
// gated by run. Assumes DIV_W >= 8 so all tap indices exist.
module rt_prescaler
    import reload_timer_pkg::*;
#(
    parameter int DIV_W = 10
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       run,
    input  logic [1:0] rate_sel,
    output logic       tick
);

    logic [DIV_W-1:0]     div_q;
    logic [DIV_W-1:0]     div_nxt;
    logic [NUM_RATES-1:0] tap_fall;

    assign div_nxt = div_q + 1'b1;

    // Divider register: counts every clock, cleared only by reset.
    always_ff @(posedge clk) begin
        if (!rst_n) div_q <= '0;
        else        div_q <= div_nxt;
    end

    // One falling-edge detector per selectable tap.
    for (genvar c = 0; c < NUM_RATES; c++) begin : g_tap
        localparam int TAP = tap_index(c, DIV_W);
        assign tap_fall[c] = div_q[TAP] & ~div_nxt[TAP];
    end

    // Tick select: pick the chosen tap edge and gate with run.
    always_comb begin
        tick = run & tap_fall[rate_sel];
    end

endmodule

// File: rtl/rt_counter.sv
// Module: counting register with reload on overflow.
// A bus write beats a tick in the same cycle. Overflow produces a registered
// one-cycle pulse aligned with the reloaded value.
module rt_counter #(
    parameter int W = 8
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         tick,
    input  logic         wr_en,
    input  logic [W-1:0] wr_data,
    input  logic [W-1:0] reload_val,
    output logic [W-1:0] count_o,
    output logic         ovf_o
);

    logic [W-1:0] cnt_q;
    logic         ovf_q;

    // Counter update: write first, then tick (increment or reload).
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cnt_q <= '0;
            ovf_q <= 1'b0;
        end else begin
            ovf_q <= 1'b0;
            if (wr_en) begin
                cnt_q <= wr_data;
            end else if (tick) begin
                if (cnt_q == '1) begin
                    cnt_q <= reload_val;
                    ovf_q <= 1'b1;
                end else begin
                    cnt_q <= cnt_q + 1'b1;
                end
            end
        end
    end

    assign count_o = cnt_q;
    assign ovf_o   = ovf_q;

endmodule

// File: rtl/rt_irq_flag.sv
// Module: sticky request flag. A set pulse wins over a bus write in the
// same cycle, so a request is never lost. Drives only one bit of the word.
module rt_irq_flag #(
    parameter int W   = 8,
    parameter int BIT = 2
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         set_pulse,
    input  logic         wr_en,
    input  logic         wr_bit,
    output logic [W-1:0] flag_word,
    output logic         flag_o
);

    logic flag_q;

    // Flag state: set by request, otherwise loaded by a bus write.
    always_ff @(posedge clk) begin
        if (!rst_n)         flag_q <= 1'b0;
        else if (set_pulse) flag_q <= 1'b1;
        else if (wr_en)     flag_q <= wr_bit;
    end

    // Word view: only the timer bit position is populated.
    always_comb begin
        flag_word      = '0;
        flag_word[BIT] = flag_q;
    end

    assign flag_o = flag_q;

endmodule

// File: rtl/reload_timer.sv
// Module: top of the reload timer. Decodes the register port, holds the
// reload and control registers, and joins prescaler, counter and flag.
// Assumes a single synchronous clock and a combinational read path.
module reload_timer
    import reload_timer_pkg::*;
#(
    parameter int DATA_W = 8,
    parameter int DIV_W  = 10
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic              bus_wr,
    input  logic [DATA_W-1:0] bus_wdata,
    output logic [DATA_W-1:0] bus_rdata,
    output logic              irq_o,
    output logic              irq_flag_o
);

    logic [DATA_W-1:0] reload_q;
    logic [CTRL_W-1:0] ctrl_q;
    logic [DATA_W-1:0] count_w;
    logic [DATA_W-1:0] flag_word_w;
    logic              tick_w;
    logic              cnt_wr_w;
    logic              reload_wr_w;
    logic              ctrl_wr_w;
    logic              flag_wr_w;
    reg_sel_e          sel_w;

    assign sel_w = reg_sel_e'(bus_addr);

    // Write decode: one strobe per register.
    always_comb begin
        cnt_wr_w    = bus_wr && (sel_w == SEL_COUNT);
        reload_wr_w = bus_wr && (sel_w == SEL_RELOAD);
        ctrl_wr_w   = bus_wr && (sel_w == SEL_CTRL);
        flag_wr_w   = bus_wr && (sel_w == SEL_FLAG);
    end

    // Reload and control registers.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            reload_q <= '0;
            ctrl_q   <= '0;
        end else begin
            if (reload_wr_w) reload_q <= bus_wdata;
            if (ctrl_wr_w)   ctrl_q   <= bus_wdata[CTRL_W-1:0];
        end
    end

    rt_prescaler #(.DIV_W(DIV_W)) presc_i (
        .clk      (clk),
        .rst_n    (rst_n),
        .run      (ctrl_q[RUN_BIT]),
        .rate_sel (ctrl_q[1:0]),
        .tick     (tick_w)
    );

    rt_counter #(.W(DATA_W)) cnt_i (
        .clk        (clk),
        .rst_n      (rst_n),
        .tick       (tick_w),
        .wr_en      (cnt_wr_w),
        .wr_data    (bus_wdata),
        .reload_val (reload_q),
        .count_o    (count_w),
        .ovf_o      (irq_o)
    );

    rt_irq_flag #(.W(DATA_W), .BIT(TIMER_BIT)) flag_i (
        .clk       (clk),
        .rst_n     (rst_n),
        .set_pulse (irq_o),
        .wr_en     (flag_wr_w),
        .wr_bit    (bus_wdata[TIMER_BIT]),
        .flag_word (flag_word_w),
        .flag_o    (irq_flag_o)
    );

    // Read mux: unused control bits read zero.
    always_comb begin
        bus_rdata = '0;
        case (sel_w)
            SEL_COUNT:  bus_rdata = count_w;
            SEL_RELOAD: bus_rdata = reload_q;
            SEL_CTRL:   bus_rdata[CTRL_W-1:0] = ctrl_q;
            SEL_FLAG:   bus_rdata = flag_word_w;
            default:    bus_rdata = '0;
        endcase
    end

endmodule

// File: rtl/reload_timer_chk.sv
// Module: assertion checker bound into reload_timer. Observes the tick,
// counter, reload and flag signals. Drives nothing.
module reload_timer_chk #(
    parameter int DATA_W = 8
) (
    input logic              clk,
    input logic              rst_n,
    input logic              tick,
    input logic              run,
    input logic              cnt_wr,
    input logic [DATA_W-1:0] wdata,
    input logic [DATA_W-1:0] cnt,
    input logic [DATA_W-1:0] reload,
    input logic              irq,
    input logic              flag
);

    // R5: an overflowing tick loads the reload value.
    a_r5_reload: assert property (@(posedge clk) disable iff (!rst_n)
        (tick && !cnt_wr && cnt == '1) |=> (cnt == $past(reload)));

    // R4: no tick while stopped.
    a_r4_tick_gated: assert property (@(posedge clk) disable iff (!rst_n)
        tick |-> run);

    // R4: counter frozen when stopped and not written.
    a_r4_halt: assert property (@(posedge clk) disable iff (!rst_n)
        (!run && !cnt_wr) |=> $stable(cnt));

    // R6: request lasts a single cycle.
    a_r6_single_pulse: assert property (@(posedge clk) disable iff (!rst_n)
        irq |=> !irq);

    // R6: request only follows an overflowing tick.
    a_r6_pulse_cause: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(irq) |-> $past(tick && !cnt_wr && cnt == '1));

    // R7: flag latches the request.
    a_r7_flag_set: assert property (@(posedge clk) disable iff (!rst_n)
        irq |=> flag);

    // R8: a counter write lands unchanged.
    a_r8_write_wins: assert property (@(posedge clk) disable iff (!rst_n)
        cnt_wr |=> (cnt == $past(wdata)));

endmodule

bind reload_timer reload_timer_chk #(.DATA_W(DATA_W)) chk_i (
    .clk    (clk),
    .rst_n  (rst_n),
    .tick   (tick_w),
    .run    (ctrl_q[2]),
    .cnt_wr (cnt_wr_w),
    .wdata  (bus_wdata),
    .cnt    (count_w),
    .reload (reload_q),
    .irq    (irq_o),
    .flag   (irq_flag_o)
);

// File: tb/reload_timer_tb_top.sv
// Bench: directed and seeded-random scenarios for reload_timer.
// Inputs are driven on falling clock edges and outputs sampled 1 ns later.
module reload_timer_tb_top;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic [1:0] bus_addr = 2'd0;
    logic       bus_wr = 1'b0;
    logic [7:0] bus_wdata = 8'd0;
    logic [7:0] bus_rdata;
    logic       irq_o;
    logic       irq_flag_o;

    int checks = 0;
    int errors = 0;
    int cyc = 0;

    reload_timer dut_i (
        .clk        (clk),
        .rst_n      (rst_n),
        .bus_addr   (bus_addr),
        .bus_wr     (bus_wr),
        .bus_wdata  (bus_wdata),
        .bus_rdata  (bus_rdata),
        .irq_o      (irq_o),
        .irq_flag_o (irq_flag_o)
    );

    always #4 clk = ~clk;

    // Cycle counter and watchdog.
    always @(posedge clk) begin
        cyc <= cyc + 1;
        if (cyc > 190000) begin
            checks++;
            errors++;
            $display("FAIL watchdog: actual %0d cycles expected < 190000", cyc);
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

    function automatic int exp_period(input int code);
        case (code)
            0:       return 1024;
            1:       return 16;
            2:       return 64;
            default: return 256;
        endcase
    endfunction

    task automatic check(input string req, input int act, input int exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s: actual %0h expected %0h", req, act, exp);
        end
    endtask

    task automatic wr(input logic [1:0] a, input logic [7:0] d);
        @(negedge clk);
        bus_addr = a; bus_wdata = d; bus_wr = 1'b1;
        @(negedge clk);
        bus_wr = 1'b0; bus_addr = 2'd0;
        #1;
    endtask

    task automatic rd(input logic [1:0] a, output logic [7:0] d);
        bus_addr = a;
        #1;
        d = bus_rdata;
        bus_addr = 2'd0;
        #1;
    endtask

    // Waits for the counter to change; returns the cycle of the change.
    task automatic wait_change(output int at);
        logic [7:0] v0;
        v0 = bus_rdata;
        at = -1;
        for (int i = 0; i < 3000; i++) begin
            @(negedge clk); #1;
            if (bus_rdata != v0) begin at = cyc; break; end
        end
    endtask

    task automatic measure(input int code);
        int t1, t2;
        wr(2'd2, 8'd0);
        wr(2'd1, 8'd0);
        wr(2'd0, 8'd0);
        wr(2'd2, 8'(4 | code));
        wait_change(t1);
        wait_change(t2);
        check($sformatf("R3 period code %0d", code), t2 - t1, exp_period(code));
    endtask

    // Runs to overflow and checks reload, pulse and flag.
    task automatic reload_run(input int code, input logic [7:0] m, input logic [7:0] start);
        logic [7:0] prev, f;
        int pulses = 0;
        bit done = 0;
        wr(2'd2, 8'd0);
        wr(2'd1, m);
        wr(2'd0, start);
        wr(2'd3, 8'd0);
        wr(2'd2, 8'(4 | code));
        prev = bus_rdata;
        for (int i = 0; i < 6000 && !done; i++) begin
            @(negedge clk); #1;
            if (irq_o) pulses++;
            if (bus_rdata != prev || (prev == 8'hFF && irq_o)) begin
                if (prev == 8'hFF) begin
                    check("R5 reload value", bus_rdata, m);
                    check("R6 pulse with reload", irq_o, 1);
                    check("R6 no early pulse", pulses, 1);
                    @(negedge clk); #1;
                    check("R6 pulse one cycle", irq_o, 0);
                    rd(2'd3, f);
                    check("R7 flag set", f, 8'h04);
                    check("R7 flag pin", irq_flag_o, 1);
                    done = 1;
                end
                prev = bus_rdata;
            end
        end
        check("R5 overflow reached", done, 1);
        wr(2'd2, 8'd0);
    endtask

    initial begin
        logic [7:0] v;
        int t0;
        void'($urandom(32'd7301));

        repeat (3) @(posedge clk);
        @(negedge clk); rst_n = 1'b1; #1;

        // R1: reset state
        for (int a = 0; a < 4; a++) begin
            rd(2'(a), v);
            check($sformatf("R1 reg %0d reset", a), v, 0);
        end
        check("R1 irq low", irq_o, 0);

        // R2: read-back
        wr(2'd1, 8'hA5); rd(2'd1, v); check("R2 reload rw", v, 8'hA5);
        wr(2'd0, 8'h3C); rd(2'd0, v); check("R2 counter rw", v, 8'h3C);
        wr(2'd2, 8'hF8); rd(2'd2, v); check("R2 ctrl upper masked", v, 8'h00);
        wr(2'd2, 8'h03); rd(2'd2, v); check("R2 ctrl low bits", v, 8'h03);

        // R7: flag write behaviour
        wr(2'd3, 8'hFF); rd(2'd3, v); check("R7 flag write set", v, 8'h04);
        wr(2'd3, 8'h00); rd(2'd3, v); check("R7 flag write clear", v, 8'h00);

        // R4: halted counter
        wr(2'd2, 8'h01);
        wr(2'd0, 8'hFF);
        t0 = 0;
        for (int i = 0; i < 500; i++) begin
            @(negedge clk); #1;
            if (irq_o) t0++;
        end
        rd(2'd0, v); check("R4 halted value", v, 8'hFF);
        check("R4 no overflow while halted", t0, 0);

        // R3: every rate code
        for (int c = 0; c < 4; c++) measure(c);

        // R5/R6/R7: directed corners, then seeded random
        reload_run(1, 8'h00, 8'hFE);
        reload_run(1, 8'hFF, 8'hFF);
        for (int k = 0; k < 8; k++) begin
            reload_run(int'($urandom_range(3, 0)), 8'($urandom_range(255, 0)),
                       8'($urandom_range(255, 252)));
        end

        // R8: write lands exactly on a tick edge (code 1, period 16)
        wr(2'd1, 8'h11);
        wr(2'd0, 8'h20);
        wr(2'd2, 8'h05);
        wait_change(t0);
        repeat (15) @(negedge clk);
        bus_addr = 2'd0; bus_wdata = 8'hFF; bus_wr = 1'b1;
        @(negedge clk);
        bus_wr = 1'b0; #1;
        check("R8 write beats tick", bus_rdata, 8'hFF);
        check("R8 no overflow on write", irq_o, 0);
        wr(2'd2, 8'd0);

        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

endmodule